// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a chip. It runs the standard sixteen-state test controller from the test clock and mode input. It holds an 8-bit instruction register and decodes the instruction to pick which data register sits between the serial input and the serial output. Internally it holds a one-bit pass-through register, a 32-bit identification register and a 32-bit user-code register. The boundary register lives outside the block. It is reached through a scan-in output, a scan-out input and a set of decoded strobes: capture, shift, update, an output-takeover mode, and a request to float all pins.

Every instruction the block does not recognise selects the pass-through register, and so do the programming-mode opcodes. The board tester can therefore always traverse the chain. Capture, shift and state changes happen on the rising test-clock edge. The serial output and its enable change on the falling edge. The synchronous reset input `rst` acts as the optional test reset.

Top module: `scan_tap`

## Requirements
- R1: While `rst` is high, and in the Test-Logic-Reset state, the instruction register is loaded with the identification opcode 8'h16. After a reset, a data scan with no instruction load returns the identification word.
- R2: In Capture-IR the instruction shift register loads 8'h19, so the serial order out is 1,0,0,1,1,0,0,0 (bit 0 first). The undefined bit 2 is driven to 0.
- R3: Opcodes 8'h00 and 8'hFF, and every opcode not listed in R4 to R8 (for example 8'h03 or 8'h07), select the one-bit pass-through register. That register captures 0, so a data scan returns 0 followed by the input delayed by one clock.
- R4: Opcodes 8'h16, 8'h19 and 8'h1D select the identification register, which captures 32'h0128_1043. That word is a version of 0 in bits 31:28, a part field of 16'h1281 in bits 27:12 and a maker field of 12'h043 in bits 11:0. It is shifted out LSB first.
- R5: Opcode 8'h17 selects a 32-bit user-code register that captures all ones.
- R6: Opcodes 8'h1C (sample and preload), 8'hD5 (external test) and 8'h2C (internal test) select the external boundary register. While one of them is active, the capture, shift and update strobes pulse in Capture-DR, Shift-DR and Update-DR, and the serial output follows the boundary scan-out.
- R7: The boundary mode output is high while the current instruction is 8'hD5, 8'h2C or 8'h20 (clamp), and low for any other instruction.
- R8: Opcode 8'h18 raises the float request and selects the pass-through register. Opcode 8'h20 also selects the pass-through register.
- R9: Five test clocks with the mode input high bring the controller to Test-Logic-Reset from any state, including Shift-DR.
- R10: The output enable is high only while the controller is in Shift-IR or Shift-DR. Output data and enable are updated on the falling test-clock edge.
- R11: A new instruction takes effect in Update-IR. Instruction bits are shifted in LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| bnd_si | output | 1 | Serial input to the external boundary register |
| bnd_so | input | 1 | Serial output of the external boundary register |
| bnd_capture | output | 1 | Boundary capture strobe |
| bnd_shift | output | 1 | Boundary shift strobe |
| bnd_update | output | 1 | Boundary update strobe |
| bnd_mode | output | 1 | Boundary cells drive the pins |
| hiz_req | output | 1 | Request to float all pins |

## Verification
The bench scans every opcode that shares a register and checks the value read back. A decode that missed one of the three identification aliases would return a single 0 and then a delayed copy of the input instead of 32'h0128_1043. Unlisted and programming opcodes are scanned to prove that they fall back to the one-bit path. A design that let them open a dead register would hand back a constant stream. The bench leaves a data scan in the middle with five high mode bits and then reads data without loading an instruction. A controller that did not force the identification opcode on reset would then return pass-through data. The bench also checks that the output is enabled only during shift states, and that the boundary mode bit follows the clamp and test opcodes and not sample.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W   = 8;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_PASS, PATH_IDENT, PATH_USER, PATH_BOUND
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     drive;
        logic     float_all;
    } op_decode_t;

    localparam logic [IR_W-1:0] OP_IDENT_DEF = 8'h16;
    localparam logic [IR_W-1:0] IR_CAPTURE   = 8'h19;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_DR_SEL : ST_IDLE;
            ST_DR_SEL: return m ? ST_IR_SEL : ST_DR_CAP;
            ST_DR_CAP: return m ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_SHF: return m ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_EX1: return m ? ST_DR_UPD : ST_DR_PAU;
            ST_DR_PAU: return m ? ST_DR_EX2 : ST_DR_PAU;
            ST_DR_EX2: return m ? ST_DR_UPD : ST_DR_SHF;
            ST_DR_UPD: return m ? ST_DR_SEL : ST_IDLE;
            ST_IR_SEL: return m ? ST_RESET  : ST_IR_CAP;
            ST_IR_CAP: return m ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_SHF: return m ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_EX1: return m ? ST_IR_UPD : ST_IR_PAU;
            ST_IR_PAU: return m ? ST_IR_EX2 : ST_IR_PAU;
            ST_IR_EX2: return m ? ST_IR_UPD : ST_IR_SHF;
            default:   return m ? ST_DR_SEL : ST_IDLE;
        endcase
    endfunction

    function automatic op_decode_t op_decode(logic [IR_W-1:0] op);
        op_decode_t d;
        d = '{path: PATH_PASS, drive: 1'b0, float_all: 1'b0};
        case (op)
            8'h16, 8'h19, 8'h1D: d.path = PATH_IDENT;
            8'h17:               d.path = PATH_USER;
            8'h1C:               d.path = PATH_BOUND;
            8'hD5, 8'h2C: begin
                d.path  = PATH_BOUND;
                d.drive = 1'b1;
            end
            8'h20:               d.drive = 1'b1;
            8'h18:               d.float_all = 1'b1;
            default:             d.path = PATH_PASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         tdi,
    input  tap_state_e   state,
    output logic [W-1:0] ir_sr,
    output logic [W-1:0] ir_q
);
    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            ir_q  <= W'(OP_IDENT_DEF);
            ir_sr <= '0;
        end else begin
            case (state)
                ST_IR_CAP: ir_sr <= W'(IR_CAPTURE);
                ST_IR_SHF: ir_sr <= {tdi, ir_sr[W-1:1]};
                ST_IR_UPD: ir_q  <= ir_sr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int               W         = WORD_W,
    parameter logic [WORD_W-1:0] IDENT    = 32'h0128_1043,
    parameter logic [WORD_W-1:0] USERWORD = '1
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       bnd_so,
    output logic       dr_so
);
    logic         pass_q;
    logic [W-1:0] ident_q;
    logic [W-1:0] user_q;

    wire cap = (state == ST_DR_CAP);
    wire shf = (state == ST_DR_SHF);

    always_ff @(posedge tck) begin
        if (rst) begin
            pass_q  <= 1'b0;
            ident_q <= '0;
            user_q  <= '0;
        end else begin
            if (path == PATH_PASS) begin
                if (cap)      pass_q <= 1'b0;
                else if (shf) pass_q <= tdi;
            end
            if (path == PATH_IDENT) begin
                if (cap)      ident_q <= IDENT[W-1:0];
                else if (shf) ident_q <= {tdi, ident_q[W-1:1]};
            end
            if (path == PATH_USER) begin
                if (cap)      user_q <= USERWORD[W-1:0];
                else if (shf) user_q <= {tdi, user_q[W-1:1]};
            end
        end
    end

    always_comb begin
        case (path)
            PATH_IDENT: dr_so = ident_q[0];
            PATH_USER:  dr_so = user_q[0];
            PATH_BOUND: dr_so = bnd_so;
            default:    dr_so = pass_q;
        endcase
    end
endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic bnd_si,
    input  logic bnd_so,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic bnd_mode,
    output logic hiz_req
);
    tap_state_e      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    logic            dr_so;
    op_decode_t      dec;

    scan_tap_ctrl u_ctrl (.tck(tck), .rst(rst), .tms(tms), .state(state));

    scan_tap_ir #(.W(IR_W)) u_ir (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state),
        .ir_sr(ir_sr), .ir_q(ir_q)
    );

    assign dec = op_decode(ir_q);

    scan_tap_dr u_dr (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state),
        .path(dec.path), .bnd_so(bnd_so), .dr_so(dr_so)
    );

    wire bsel = (dec.path == PATH_BOUND);
    assign bnd_si      = tdi;
    assign bnd_capture = bsel && state == ST_DR_CAP;
    assign bnd_shift   = bsel && state == ST_DR_SHF;
    assign bnd_update  = bsel && state == ST_DR_UPD;
    assign bnd_mode    = dec.drive;
    assign hiz_req     = dec.float_all;

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_IR_SHF) ? ir_sr[0] : dr_so;
            tdo_oe <= (state == ST_IR_SHF) || (state == ST_DR_SHF);
        end
    end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic            tck,
    input logic            rst,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] ir_q,
    input logic            bnd_capture,
    input logic            bnd_shift,
    input logic            bnd_update,
    input logic            bnd_mode,
    input logic            hiz_req
);
    a_r1_reset_loads_ident: assert property (@(posedge tck)
        disable iff (rst) (state == ST_RESET) |=> (ir_q == 8'h16));

    a_r11_update_takes_shift: assert property (@(posedge tck)
        disable iff (rst) (state == ST_IR_UPD) |=> (ir_q == $past(ir_sr)));

    a_r2_capture_pattern: assert property (@(posedge tck)
        disable iff (rst) (state == ST_IR_CAP) |=> (ir_sr == 8'h19));

    a_r6_strobes_exclusive: assert property (@(posedge tck)
        disable iff (rst) $onehot0({bnd_capture, bnd_shift, bnd_update}));

    a_r8_float_not_drive: assert property (@(posedge tck)
        disable iff (rst) hiz_req |-> !bnd_mode);

    a_r9_shift_exit: assert property (@(posedge tck)
        disable iff (rst) (state == ST_DR_SHF && tms) |=> (state == ST_DR_EX1));

    a_r9_reset_holds: assert property (@(posedge tck)
        disable iff (rst) (state == ST_RESET && tms) |=> (state == ST_RESET));
endmodule

bind scan_tap scan_tap_chk u_chk (.*);

// File: tb/scan_tap_test.sv
module scan_tap_test;
    localparam time TCK_PERIOD = 40ns;

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0, bnd_so = 1'b1;
    logic tdo, tdo_oe, bnd_si, bnd_capture, bnd_shift, bnd_update, bnd_mode, hiz_req;
    int n_chk = 0, n_fail = 0;

    localparam logic [31:0] ID_WORD = 32'h0128_1043;

    scan_tap uut (.*);

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(logic m, logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    // from Run-Test/Idle; returns captured instruction bits
    task automatic load_ir(logic [7:0] op, output logic [7:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 8; i++) begin
            cap[i] = tdo;
            tick(i == 7, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(int n, logic [31:0] din, output logic [31:0] dout, output logic oe_seen);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        oe_seen = tdo_oe;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic oe;
        check("R10 oe low in reset", tdo_oe, 0);
        check("R7 mode low after reset", bnd_mode, 0);
        tick(0, 0);
        check("R10 oe low in idle", tdo_oe, 0);
        scan_dr(32, 32'h0, d, oe);
        check("R1 ident after reset", d, ID_WORD);
        check("R10 oe high in shift-dr", oe, 1);
    endtask

    task automatic t_bypass(logic [7:0] op);
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(op, c);
        check("R2 capture pattern", c, 8'h19);
        scan_dr(8, 32'hA5, d, oe);
        check($sformatf("R3 pass-through op %h", op), d, {24'h0, 8'h4A});
    endtask

    task automatic t_ident(logic [7:0] op);
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(op, c);
        scan_dr(32, 32'hFFFF_FFFF, d, oe);
        check($sformatf("R4 ident op %h", op), d, ID_WORD);
    endtask

    task automatic t_user;
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(8'h17, c);
        scan_dr(32, 32'h0, d, oe);
        check("R5 user word", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_bound(logic [7:0] op, logic exp_mode);
        logic [7:0] c; logic [31:0] d;
        load_ir(op, c);
        check($sformatf("R7 mode op %h", op), bnd_mode, exp_mode);
        check("R6 bnd_si follows tdi", bnd_si, tdi);
        tick(1, 0); tick(0, 0);
        check("R6 capture strobe", bnd_capture, 1);
        tick(0, 0);
        check("R6 shift strobe", bnd_shift, 1);
        for (int i = 0; i < 4; i++) begin
            bnd_so = i[0];
            tick(i == 3, 0);
            d[i] = tdo;
        end
        check("R6 tdo follows boundary scan-out", d[3:0], 4'b1010);
        tick(1, 0);
        check("R6 update strobe", bnd_update, 1);
        tick(0, 0);
        bnd_so = 1'b1;
    endtask

    task automatic t_float_clamp;
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(8'h18, c);
        check("R8 float request", hiz_req, 1);
        scan_dr(4, 32'h5, d, oe);
        check("R8 float uses pass-through", d[3:0], 4'hA);
        load_ir(8'h20, c);
        check("R8 float cleared", hiz_req, 0);
        check("R7 clamp mode", bnd_mode, 1);
        scan_dr(4, 32'h3, d, oe);
        check("R8 clamp uses pass-through", d[3:0], 4'h6);
    endtask

    task automatic t_tms_reset;
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(8'h00, c);
        tick(1, 0); tick(0, 0); tick(0, 0);
        check("R10 oe high in shift-dr", tdo_oe, 1);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check("R10 oe low after escape", tdo_oe, 0);
        tick(0, 0);
        scan_dr(32, 32'h0, d, oe);
        check("R9 five high tms reach reset", d, ID_WORD);
    endtask

    task automatic t_ir_order;
        logic [7:0] c; logic [31:0] d; logic oe;
        load_ir(8'hD5, c);
        check("R11 update applies EXTEST", bnd_mode, 1);
        load_ir(8'h1C, c);
        check("R11 sample clears mode", bnd_mode, 0);
        load_ir(8'hAB, c);
        check("R2 capture after prior load", c, 8'h19);
        scan_dr(3, 32'h7, d, oe);
        check("R3 unlisted op", d[2:0], 3'b110);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge tck);
                @(negedge tck); rst = 1'b0; #1;
                t_reset();
                t_bypass(8'h00); t_bypass(8'hFF); t_bypass(8'h03); t_bypass(8'h07);
                t_ident(8'h16); t_ident(8'h19); t_ident(8'h1D);
                t_user();
                t_bound(8'h1C, 0); t_bound(8'hD5, 1); t_bound(8'h2C, 1);
                t_float_clamp();
                t_ir_order();
                t_tms_reset();
            end
            begin
                repeat (20000) @(posedge tck);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule